// File: doc/BRIEF.md
# Mouse Motion Packet Encoder

This block converts a single pointer event into a fixed five-byte packet and stores the bytes in a byte queue that a host drains one byte at a time. Each event carries signed X and Y motion and the levels of three buttons. The packet carries the following, in order:

- a header byte whose three low bits are active-low button flags;
- the X motion, clamped to a symmetric 8-bit range;
- the Y motion, sign-inverted and then clamped;
- two zero bytes.

A sequencer captures the event, then writes one packet byte into the queue per clock. While it is writing, it shows a busy flag, and new events are refused. The host sees the head byte on a read port, together with an available flag. A pop strobe consumes the head byte. A one-cycle receive pulse tells the host that a byte has just arrived, or that bytes are still waiting after a pop. Motion is not accumulated across events, and there is no wheel data.

Top module: `mouse_pkt_enc`

## Requirements
- R1: The first byte of a packet is 0x87 with bit 2 cleared when left is pressed, bit 1 cleared when middle is pressed and bit 0 cleared when right is pressed; bits 7..3 are 10000.
- R2: The second byte is dx clamped to -127..+127, in 8-bit two's complement (dx = -128 gives 0x81).
- R3: The third byte is -dy clamped to -127..+127, in 8-bit two's complement (dy = -128 gives 0x7F).
- R4: The fourth and fifth bytes are 0x00.
- R5: An event is taken when `evt_valid_i` is high and `busy_o` is low. `busy_o` is high for exactly the five cycles after that edge, and the five bytes enter the queue on the five edges that end those cycles. Events presented while `busy_o` is high are ignored and never interleaved.
- R6: The queue holds DEPTH (default 256) bytes in first-in first-out order. A byte arriving while the queue is full is dropped, even when a pop happens in the same cycle.
- R7: With the queue empty, `rd_data_o` is 0x00 and a pop changes nothing.
- R8: `rx_event_o` is high for one cycle after each edge that stores a byte. It is also high after each edge that pops a byte and leaves the queue non-empty.
- R9: Reset (`rst_ni` low) empties the queue, returns the sequencer to idle and clears `rx_event_o`.
- R10: `rd_avail_o` is high exactly when the queue is non-empty, and `rd_data_o` then shows the oldest byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_valid_i | input | 1 | Pointer event strobe |
| dx_i | input | MOT_W | Signed X motion |
| dy_i | input | MOT_W | Signed Y motion |
| btn_left_i | input | 1 | Left button pressed |
| btn_mid_i | input | 1 | Middle button pressed |
| btn_right_i | input | 1 | Right button pressed |
| busy_o | output | 1 | Packet being written, events refused |
| rd_pop_i | input | 1 | Consume head byte |
| rd_avail_o | output | 1 | Queue non-empty |
| rd_data_o | output | 8 | Head byte, 0x00 when empty |
| rx_event_o | output | 1 | Receive-available pulse |

## Verification
A packet byte can be written into the queue in the same cycle that the host pops the head. This matters most when the queue is full, where the write must still be dropped while the pop goes ahead, and where the receive pulse depends on the combined fill level. The bench provokes this by filling the queue beyond capacity and then holding both the event strobe and the pop strobe high. It also uses random traffic in which writes and pops often coincide. A cycle model in the bench, computed from the requirements, judges every cycle: head byte, available flag, busy flag and receive pulse.

// File: rtl/mouse_pkt_pkg.sv
package mouse_pkt_pkg;
  localparam int PKT_LEN = 5;
  localparam int SLOT_W  = $clog2(PKT_LEN);
  localparam logic [7:0] HDR_BASE = 8'h87;
  typedef logic [PKT_LEN-1:0][7:0] pkt_t;
endpackage

// File: rtl/mouse_pkt_fmt.sv
module mouse_pkt_fmt
  import mouse_pkt_pkg::*;
#(
  parameter int MOT_W = 10
) (
  input  logic [MOT_W-1:0] dx_i,
  input  logic [MOT_W-1:0] dy_i,
  input  logic             btn_left_i,
  input  logic             btn_mid_i,
  input  logic             btn_right_i,
  output pkt_t             pkt_o
);
  localparam int W1 = MOT_W + 1;

  logic signed [W1-1:0] dx_ext, dy_neg;
  logic [7:0] x_byte, y_byte, hdr;

  assign dx_ext = {dx_i[MOT_W-1], dx_i};
  assign dy_neg = -{dy_i[MOT_W-1], dy_i};

  generate
    if (MOT_W > 7) begin : g_clamp
      localparam logic signed [W1-1:0] LIM_HI = W1'(127);
      localparam logic signed [W1-1:0] LIM_LO = -LIM_HI;
      always_comb begin
        if (dx_ext > LIM_HI)      x_byte = 8'h7f;
        else if (dx_ext < LIM_LO) x_byte = 8'h81;
        else                      x_byte = dx_ext[7:0];
        if (dy_neg > LIM_HI)      y_byte = 8'h7f;
        else if (dy_neg < LIM_LO) y_byte = 8'h81;
        else                      y_byte = dy_neg[7:0];
      end
    end else begin : g_pass
      // narrow motion always fits, sign-extend only
      assign x_byte = 8'(dx_ext);
      assign y_byte = 8'(dy_neg);
    end
  endgenerate

  assign hdr = {HDR_BASE[7:3], ~btn_left_i, ~btn_mid_i, ~btn_right_i};

  always_comb begin
    pkt_o = '0;
    pkt_o[0] = hdr;
    pkt_o[1] = x_byte;
    pkt_o[2] = y_byte;
  end
endmodule

// File: rtl/mouse_pkt_seq.sv
module mouse_pkt_seq
  import mouse_pkt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_valid_i,
  input  pkt_t              pkt_i,
  output logic              busy_o,
  output logic              push_o,
  output logic [7:0]        push_byte_o,
  output logic [SLOT_W-1:0] slot_o
);
  logic              busy_q;
  logic [SLOT_W-1:0] slot_q;
  pkt_t              pkt_q;
  logic              last_slot;

  assign last_slot = (slot_q == SLOT_W'(PKT_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      slot_q <= '0;
      pkt_q  <= '0;
    end else if (busy_q) begin
      if (last_slot) begin
        busy_q <= 1'b0;
        slot_q <= '0;
      end else begin
        slot_q <= slot_q + 1'b1;
      end
    end else if (evt_valid_i) begin
      busy_q <= 1'b1;
      slot_q <= '0;
      pkt_q  <= pkt_i;
    end
  end

  always_comb begin
    push_byte_o = 8'h00;
    for (int i = 0; i < PKT_LEN; i++) begin
      if (slot_q == SLOT_W'(i)) push_byte_o = pkt_q[i];
    end
  end

  assign busy_o = busy_q;
  assign push_o = busy_q;
  assign slot_o = slot_q;
endmodule

// File: rtl/mouse_pkt_fifo.sv
module mouse_pkt_fifo #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        push_i,
  input  logic [7:0]  push_byte_i,
  input  logic        pop_i,
  output logic        avail_o,
  output logic [7:0]  data_o,
  output logic        rx_event_o,
  output logic [AW:0] fill_o
);
  logic [7:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr_q, wr_ptr_q;
  logic [AW:0]   fill_q, fill_nxt;
  logic          push_ok, pop_ok, rx_q;

  assign push_ok = push_i && (fill_q != (AW+1)'(DEPTH));
  assign pop_ok  = pop_i && (fill_q != '0);

  always_comb begin
    fill_nxt = fill_q;
    if (push_ok) fill_nxt = fill_nxt + 1'b1;
    if (pop_ok)  fill_nxt = fill_nxt - 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wr_ptr_q] <= push_byte_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      fill_q   <= '0;
      rx_q     <= 1'b0;
    end else begin
      if (push_ok) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop_ok)  rd_ptr_q <= rd_ptr_q + 1'b1;
      fill_q <= fill_nxt;
      rx_q   <= push_ok || (pop_ok && (fill_nxt != '0));
    end
  end

  assign avail_o    = (fill_q != '0);
  assign data_o     = avail_o ? mem[rd_ptr_q] : 8'h00;
  assign rx_event_o = rx_q;
  assign fill_o     = fill_q;
endmodule

// File: rtl/mouse_pkt_enc.sv
module mouse_pkt_enc
  import mouse_pkt_pkg::*;
#(
  parameter int MOT_W = 10,
  parameter int DEPTH = 256
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_valid_i,
  input  logic [MOT_W-1:0] dx_i,
  input  logic [MOT_W-1:0] dy_i,
  input  logic             btn_left_i,
  input  logic             btn_mid_i,
  input  logic             btn_right_i,
  output logic             busy_o,
  input  logic             rd_pop_i,
  output logic             rd_avail_o,
  output logic [7:0]       rd_data_o,
  output logic             rx_event_o
);
  localparam int AW = $clog2(DEPTH);

  pkt_t              pkt_w;
  logic              push_w;
  logic [7:0]        push_byte_w;
  logic [SLOT_W-1:0] slot_w;
  logic [AW:0]       fill_w;

  mouse_pkt_fmt #(.MOT_W(MOT_W)) u_fmt (
    .dx_i        (dx_i),
    .dy_i        (dy_i),
    .btn_left_i  (btn_left_i),
    .btn_mid_i   (btn_mid_i),
    .btn_right_i (btn_right_i),
    .pkt_o       (pkt_w)
  );

  mouse_pkt_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_valid_i (evt_valid_i),
    .pkt_i       (pkt_w),
    .busy_o      (busy_o),
    .push_o      (push_w),
    .push_byte_o (push_byte_w),
    .slot_o      (slot_w)
  );

  mouse_pkt_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push_w),
    .push_byte_i (push_byte_w),
    .pop_i       (rd_pop_i),
    .avail_o     (rd_avail_o),
    .data_o      (rd_data_o),
    .rx_event_o  (rx_event_o),
    .fill_o      (fill_w)
  );
endmodule

// File: rtl/mouse_pkt_enc_chk.sv
module mouse_pkt_enc_chk
  import mouse_pkt_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_i,
  input logic              rd_pop_i,
  input logic              rd_avail_i,
  input logic [7:0]        rd_data_i,
  input logic              rx_event_i,
  input logic              push_i,
  input logic [7:0]        push_byte_i,
  input logic [SLOT_W-1:0] slot_i,
  input logic [AW:0]       fill_i
);
  localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

  AST_HDR_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && slot_i == '0) |-> (push_byte_i[7:3] == 5'b10000)); // R1
  AST_X_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && slot_i == SLOT_W'(1)) |-> (push_byte_i != 8'h80)); // R2
  AST_Y_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && slot_i == SLOT_W'(2)) |-> (push_byte_i != 8'h80)); // R3
  AST_TAIL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && slot_i >= SLOT_W'(3)) |-> (push_byte_i == 8'h00)); // R4
  AST_BUSY_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && slot_i != SLOT_W'(PKT_LEN - 1)) |=> busy_i); // R5
  AST_BUSY_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && slot_i == SLOT_W'(PKT_LEN - 1)) |=> !busy_i); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i <= FULL); // R6
  AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i == FULL && !rd_pop_i) |=> (fill_i == FULL)); // R6
  AST_EMPTY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_avail_i |-> (rd_data_i == 8'h00)); // R7
  AST_EMPTY_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_avail_i && rd_pop_i && !push_i) |=> !rd_avail_i); // R7
  AST_RX_ON_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && fill_i != FULL) |=> rx_event_i); // R8
  AST_AVAIL_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_avail_i == (fill_i != '0)); // R10
endmodule

bind mouse_pkt_enc mouse_pkt_enc_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_i      (busy_o),
  .rd_pop_i    (rd_pop_i),
  .rd_avail_i  (rd_avail_o),
  .rd_data_i   (rd_data_o),
  .rx_event_i  (rx_event_o),
  .push_i      (push_w),
  .push_byte_i (push_byte_w),
  .slot_i      (slot_w),
  .fill_i      (fill_w)
);

// File: tb/mouse_pkt_enc_tb.sv
module mouse_pkt_enc_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MOT_W = 10;
  localparam int DEPTH = 256;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic evt_valid_i = 1'b0;
  logic [MOT_W-1:0] dx_i = '0, dy_i = '0;
  logic btn_left_i = 1'b0, btn_mid_i = 1'b0, btn_right_i = 1'b0;
  logic rd_pop_i = 1'b0;
  logic busy_o, rd_avail_o, rx_event_o;
  logic [7:0] rd_data_o;

  int total = 0, bad = 0;

  // bench model
  bit        m_busy;
  int        m_slot;
  bit [7:0]  m_pkt [5];
  bit [7:0]  qb [DEPTH];
  int        qt [DEPTH];
  int        head, cnt;
  bit        m_rx;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mouse_pkt_enc #(.MOT_W(MOT_W), .DEPTH(DEPTH)) u_dut (.*);

  function automatic bit [7:0] clamp8(int v);
    if (v > 127) return 8'h7f;
    if (v < -127) return 8'h81;
    return 8'(v);
  endfunction

  function automatic bit [7:0] hdr_of(bit l, bit m, bit r);
    return 8'h87 & ~{5'b0, l, m, r};
  endfunction

  function automatic string tag_of(int t);
    case (t)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_busy = 0; m_slot = 0; head = 0; cnt = 0; m_rx = 0;
  endtask

  task automatic check_ports();
    chk("R10 avail", int'(rd_avail_o), int'(cnt != 0));
    if (cnt != 0) chk({tag_of(qt[head]), " R6 R10 head"}, int'(rd_data_o), int'(qb[head]));
    else          chk("R7 empty data", int'(rd_data_o), 0);
    chk("R5 busy", int'(busy_o), int'(m_busy));
    chk("R8 rx_event", int'(rx_event_o), int'(m_rx));
  endtask

  // one cycle: check, drive, advance model
  task automatic step(bit ev, int dx, int dy, bit [2:0] b, bit pop);
    bit push_ok, pop_ok;
    int tail;
    @(negedge clk_i);
    check_ports();
    evt_valid_i = ev; dx_i = MOT_W'(dx); dy_i = MOT_W'(dy);
    {btn_left_i, btn_mid_i, btn_right_i} = b;
    rd_pop_i = pop;
    push_ok = m_busy && (cnt < DEPTH);
    pop_ok  = pop && (cnt > 0);
    tail = (head + cnt) % DEPTH;
    if (push_ok) begin
      qb[tail] = m_pkt[m_slot];
      qt[tail] = m_slot;
    end
    if (pop_ok) begin head = (head + 1) % DEPTH; cnt--; end
    if (push_ok) cnt++;
    m_rx = push_ok || (pop_ok && cnt > 0);
    if (m_busy) begin
      if (m_slot == 4) m_busy = 0; else m_slot++;
    end else if (ev) begin
      m_busy = 1; m_slot = 0;
      m_pkt[0] = hdr_of(b[2], b[1], b[0]);
      m_pkt[1] = clamp8(dx);
      m_pkt[2] = clamp8(-dy);
      m_pkt[3] = 8'h00;
      m_pkt[4] = 8'h00;
    end
  endtask

  task automatic drain();
    for (int i = 0; i < DEPTH + 4; i++) step(0, 0, 0, 3'b0, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int dxs [8] = '{0, 127, 128, -128, -512, 511, -127, 5};
    int dys [8] = '{0, -127, -128, 128, -512, 511, 127, -3};
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R9 reset state, R7 pops on empty
    for (int i = 0; i < 3; i++) step(0, 0, 0, 3'b0, 1);
    // R1..R4 directed packets, corner motion values
    for (int k = 0; k < 8; k++) begin
      step(1, dxs[k], dys[k], 3'(k), 0);
      for (int i = 0; i < 6; i++) step(0, 0, 0, 3'b0, 0);
    end
    drain();
    // R5 event held high across busy
    for (int i = 0; i < 23; i++) step(1, i * 40 - 300, 200 - i * 17, 3'(i), 0);
    drain();
    // R6 overflow, then full with coincident push and pop
    for (int i = 0; i < 330; i++) step(1, i % 200, -(i % 150), 3'(i), 0);
    for (int i = 0; i < 60; i++) step(1, -i, i, 3'(i), 1);
    drain();
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int dx, dy;
      dx = int'($urandom_range(0, 1023)) - 512;
      dy = int'($urandom_range(0, 1023)) - 512;
      step(($urandom_range(0, 9) < 3), dx, dy, 3'($urandom_range(0, 7)),
           ($urandom_range(0, 9) < 4));
    end
    // R9 reset with data queued and packet in flight
    for (int i = 0; i < 14; i++) step(1, 9, 9, 3'b101, 0);
    @(negedge clk_i);
    check_ports();
    rst_ni = 1'b0;
    evt_valid_i = 1'b0;
    rd_pop_i = 1'b0;
    model_reset();
    @(negedge clk_i);
    chk("R9 reset avail", int'(rd_avail_o), 0);
    chk("R9 reset busy", int'(busy_o), 0);
    chk("R9 reset rx", int'(rx_event_o), 0);
    chk("R9 reset data", int'(rd_data_o), 0);
    rst_ni = 1'b1;
    step(1, -7, 7, 3'b010, 0);
    for (int i = 0; i < 8; i++) step(0, 0, 0, 3'b0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule